// File: doc/BRIEF.md
# Eager Transactional Conflict Detector

This block sits beside a shared coherence point and judges each incoming coherence request against the transactional footprint of every core that is running a transaction. For every tracked line it holds one read mark and one write mark per core. A request that collides with another core's footprint is refused with a NACK in the same cycle. The requester is not aborted: it stalls and retries until the core it collided with finishes. Transactional writes are assumed to land in place at once, with the old value logged elsewhere. That log, its replay and all data movement stay outside this block.

Every transaction takes an age stamp from a global counter when it begins, and it keeps that stamp through any abort until it commits, so a transaction that keeps losing eventually becomes the oldest. A core that refuses an older requester raises a possible-cycle flag. If a flagged core is later refused by an older holder, a wait cycle may exist, and the flagged requester is told to abort instead of stalling. Commit is the fast path: it wipes the core's marks and releases every core stalled on it in the following cycle.

Requests arrive one per cycle on a shared channel that carries the requesting core's index. Begin and commit are per-core strobes.

Top module: `eager_conflict_unit`

## Requirements
- R1: After reset no core is active or stalled, every mark is clear and the stamp counter is 0. With no request presented, reqNack and reqAbort are low.
- R2: A read conflicts only when another core holds the write mark on that line. A read of a line that only other cores have read is granted.
- R3: A write conflicts when another core holds the read mark or the write mark on that line.
- R4: Marks held by the requesting core itself never cause a conflict.
- R5: reqNack and reqAbort are combinational and answer the request presented in the same cycle. A NACKed requester shows stalled high from the next cycle and gains no mark.
- R6: A commit ends the core's transaction, clears all of its marks and drops its stamp. A core stalled on it shows stalled low in the cycle after the commit, and its retry is then granted when no other conflict remains.
- R7: A request with reqTrans low, or from a core with no running transaction, follows the same conflict rules and is NACKed the same way. When granted, it sets no mark.
- R8: At begin, a core without a stamp takes the current counter value. The counter starts at 0 and rises by 1 in each cycle in which at least one core takes a stamp. Cores that begin in the same cycle share a value, and the lower index counts as older. The stamp survives an abort and is released at commit.
- R9: A core raises its possible-cycle flag when it NACKs an older transactional requester. A conflicting transactional requester aborts, rather than being NACKed, exactly when its own flag is set and at least one conflicting holder is older. Begin, commit and abort clear the flag.
- R10: An abort ends the requester's transaction and clears its marks. Cores stalled on the aborting core are released in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| beginTx | input | NUM_CORES | Per-core transaction start strobe (ignored while that core is active) |
| commitTx | input | NUM_CORES | Per-core commit strobe (ignored while that core is inactive) |
| reqValid | input | 1 | A coherence request is present this cycle |
| reqCore | input | $clog2(NUM_CORES) | Index of the requesting core |
| reqTrans | input | 1 | Request belongs to the requester's transaction |
| reqWrite | input | 1 | 1 = write or exclusive request, 0 = read |
| reqLine | input | $clog2(NUM_LINES) | Tracked line index |
| reqNack | output | 1 | Request refused, requester must retry |
| reqAbort | output | 1 | Requester must abort its transaction |
| txActive | output | NUM_CORES | Core has a running transaction |
| stalled | output | NUM_CORES | Core waits on one or more holders |
| txStamp | output | NUM_CORES*TS_W | Age stamp per core, core c in bits [c*TS_W +: TS_W] |

## Verification
The bench targets read-after-read sharing, which a detector with over-strict rules would refuse. It also targets re-access of a core's own line, which a detector that forgot to mask the requester would NACK forever. A directed two-core crossing of writes checks that only the flagged younger core aborts: a design that aborted on plain conflict would kill the older core, and one that never aborted would leave both stalled for good. Commits and aborts are placed right after NACKs to catch a release that arrives late or never, and aborted cores start again to catch a stamp that is wrongly refreshed.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  // Strobes from control to the tracking datapath for a granted access.
  typedef struct packed {
    logic setRd;
    logic setWr;
  } trkStrobe_t;
endpackage

// File: rtl/ecu_track_dp.sv
module ecu_track_dp
  import ecu_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic                 reqWrite,
  input  logic [LINE_W-1:0]    reqLine,
  input  trkStrobe_t           strobe,
  input  logic [NUM_CORES-1:0] clrMask,
  output logic [NUM_CORES-1:0] conflictVec
);
  logic [NUM_CORES-1:0] reqOneHot;
  logic [NUM_CORES-1:0] rdAll [NUM_LINES];
  logic [NUM_CORES-1:0] wrAll [NUM_LINES];
  logic [NUM_CORES-1:0] rowRd, rowWr;

  assign reqOneHot = NUM_CORES'(1) << reqCore;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NUM_CORES-1:0] rdRow, wrRow;
    logic lineHit;
    assign lineHit = (reqLine == LINE_W'(l));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdRow <= '0;
        wrRow <= '0;
      end else begin
        rdRow <= (rdRow & ~clrMask) | ((lineHit && strobe.setRd) ? reqOneHot : '0);
        wrRow <= (wrRow & ~clrMask) | ((lineHit && strobe.setWr) ? reqOneHot : '0);
      end
    end
    assign rdAll[l] = rdRow;
    assign wrAll[l] = wrRow;
  end

  assign rowRd = rdAll[reqLine];
  assign rowWr = wrAll[reqLine];

  // Reads collide with foreign writers, writes with any foreign mark.
  always_comb begin
    conflictVec = '0;
    if (reqValid)
      conflictVec = (reqWrite ? (rowRd | rowWr) : rowWr) & ~reqOneHot;
  end
endmodule

// File: rtl/ecu_ctrl.sv
module ecu_ctrl
  import ecu_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int TS_W = 16,
  localparam int CORE_W = $clog2(NUM_CORES)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CORES-1:0]      beginTx,
  input  logic [NUM_CORES-1:0]      commitTx,
  input  logic                      reqValid,
  input  logic [CORE_W-1:0]         reqCore,
  input  logic                      reqTrans,
  input  logic                      reqWrite,
  input  logic [NUM_CORES-1:0]      conflictVec,
  output trkStrobe_t                strobe,
  output logic [NUM_CORES-1:0]      clrMask,
  output logic                      reqNack,
  output logic                      reqAbort,
  output logic [NUM_CORES-1:0]      txActive,
  output logic [NUM_CORES-1:0]      stalled,
  output logic [NUM_CORES*TS_W-1:0] txStamp
);
  logic [NUM_CORES-1:0] active, tsValid, cycFlag;
  logic [TS_W-1:0]      stamp    [NUM_CORES];
  logic [NUM_CORES-1:0] waitMask [NUM_CORES];
  logic [TS_W-1:0]      globalCnt;

  logic                 effTrans, anyHit;
  logic [NUM_CORES-1:0] reqOneHot, reqIsOlder, holderOlder;
  logic [NUM_CORES-1:0] flagSet, abortVec, commitVec, endNow, beginVec, newStampVec;

  assign reqOneHot = NUM_CORES'(1) << reqCore;
  assign effTrans  = reqValid & reqTrans & active[reqCore];
  assign anyHit    = |conflictVec;

  // Age order: smaller stamp is older, ties go to the lower core index.
  always_comb begin
    for (int j = 0; j < NUM_CORES; j++) begin
      reqIsOlder[j]  = (stamp[reqCore] < stamp[j]) ||
                       ((stamp[reqCore] == stamp[j]) && (reqCore < CORE_W'(j)));
      holderOlder[j] = (stamp[j] < stamp[reqCore]) ||
                       ((stamp[j] == stamp[reqCore]) && (CORE_W'(j) < reqCore));
    end
  end

  assign reqAbort    = anyHit & effTrans & cycFlag[reqCore] & (|(conflictVec & holderOlder));
  assign reqNack     = anyHit & ~reqAbort;
  assign flagSet     = (anyHit && effTrans && !reqAbort) ? (conflictVec & reqIsOlder) : '0;
  assign abortVec    = reqAbort ? reqOneHot : '0;
  assign commitVec   = commitTx & active;
  assign endNow      = commitVec | abortVec;
  assign beginVec    = beginTx & ~active;
  assign newStampVec = beginVec & ~tsValid;
  assign clrMask     = endNow;

  always_comb begin
    strobe.setRd = effTrans & ~anyHit & ~reqWrite;
    strobe.setWr = effTrans & ~anyHit &  reqWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= '0;
      tsValid   <= '0;
      cycFlag   <= '0;
      globalCnt <= '0;
      for (int c = 0; c < NUM_CORES; c++) begin
        stamp[c]    <= '0;
        waitMask[c] <= '0;
      end
    end else begin
      if (|newStampVec) globalCnt <= globalCnt + 1'b1;
      for (int c = 0; c < NUM_CORES; c++) begin
        if (abortVec[c]) begin
          active[c]  <= 1'b0;
          cycFlag[c] <= 1'b0;
        end else if (commitVec[c]) begin
          active[c]  <= 1'b0;
          tsValid[c] <= 1'b0;
          cycFlag[c] <= 1'b0;
        end else if (beginVec[c]) begin
          active[c]  <= 1'b1;
          cycFlag[c] <= 1'b0;
          if (!tsValid[c]) begin
            tsValid[c] <= 1'b1;
            stamp[c]   <= globalCnt;
          end
        end else if (flagSet[c]) begin
          cycFlag[c] <= 1'b1;
        end

        if (reqValid && reqCore == CORE_W'(c))
          waitMask[c] <= reqNack ? (conflictVec & ~endNow) : '0;
        else
          waitMask[c] <= waitMask[c] & ~endNow;
      end
    end
  end

  assign txActive = active;
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_out
    assign stalled[c] = |waitMask[c];
    assign txStamp[c*TS_W +: TS_W] = stamp[c];
  end
endmodule

// File: rtl/eager_conflict_unit.sv
module eager_conflict_unit
  import ecu_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 16,
  parameter int TS_W = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_CORES-1:0]      beginTx,
  input  logic [NUM_CORES-1:0]      commitTx,
  input  logic                      reqValid,
  input  logic [CORE_W-1:0]         reqCore,
  input  logic                      reqTrans,
  input  logic                      reqWrite,
  input  logic [LINE_W-1:0]         reqLine,
  output logic                      reqNack,
  output logic                      reqAbort,
  output logic [NUM_CORES-1:0]      txActive,
  output logic [NUM_CORES-1:0]      stalled,
  output logic [NUM_CORES*TS_W-1:0] txStamp
);
  trkStrobe_t           strobe;
  logic [NUM_CORES-1:0] clrMask, conflictVec;

  ecu_track_dp #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCore(reqCore),
    .reqWrite(reqWrite), .reqLine(reqLine), .strobe(strobe),
    .clrMask(clrMask), .conflictVec(conflictVec)
  );

  ecu_ctrl #(.NUM_CORES(NUM_CORES), .TS_W(TS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .beginTx(beginTx), .commitTx(commitTx),
    .reqValid(reqValid), .reqCore(reqCore), .reqTrans(reqTrans),
    .reqWrite(reqWrite), .conflictVec(conflictVec), .strobe(strobe),
    .clrMask(clrMask), .reqNack(reqNack), .reqAbort(reqAbort),
    .txActive(txActive), .stalled(stalled), .txStamp(txStamp)
  );
endmodule

// File: rtl/eager_conflict_unit_chk.sv
module eager_conflict_unit_chk #(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 16,
  parameter int TS_W = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [NUM_CORES-1:0]      commitTx,
  input logic                      reqValid,
  input logic [CORE_W-1:0]         reqCore,
  input logic                      reqTrans,
  input logic                      reqNack,
  input logic                      reqAbort,
  input logic [NUM_CORES-1:0]      txActive,
  input logic [NUM_CORES-1:0]      stalled,
  input logic [NUM_CORES*TS_W-1:0] txStamp
);
  a_r9_resp_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(reqNack && reqAbort));

  a_r5_resp_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    (reqNack || reqAbort) |-> reqValid);

  a_r9_abort_trans_only: assert property (@(posedge clk) disable iff (!rstN)
    reqAbort |-> (reqTrans && txActive[reqCore]));

  a_r10_abort_ends_tx: assert property (@(posedge clk) disable iff (!rstN)
    reqAbort |=> !txActive[$past(reqCore)]);

  a_r5_nack_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (reqNack && commitTx == '0) |=> stalled[$past(reqCore)]);

  a_r6_commit_ends_tx: assert property (@(posedge clk) disable iff (!rstN)
    (|(commitTx & txActive)) |=> ((txActive & $past(commitTx & txActive)) == '0));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_stamp
    a_r8_stamp_steady: assert property (@(posedge clk) disable iff (!rstN)
      (txActive[c] && $past(txActive[c])) |-> $stable(txStamp[c*TS_W +: TS_W]));
  end
endmodule

bind eager_conflict_unit eager_conflict_unit_chk #(
  .NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES), .TS_W(TS_W)
) u_chk (
  .clk(clk), .rstN(rstN), .commitTx(commitTx), .reqValid(reqValid),
  .reqCore(reqCore), .reqTrans(reqTrans), .reqNack(reqNack),
  .reqAbort(reqAbort), .txActive(txActive), .stalled(stalled), .txStamp(txStamp)
);

// File: tb/eager_conflict_unit_tb.sv
`timescale 1ns/1ps
module eager_conflict_unit_tb;
  localparam int NC = 4;
  localparam int NL = 16;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0] beginTx = '0, commitTx = '0;
  logic reqValid = 1'b0, reqTrans = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqCore = '0;
  logic [3:0] reqLine = '0;
  logic reqNack, reqAbort;
  logic [NC-1:0] txActive, stalled;
  logic [NC*TW-1:0] txStamp;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  eager_conflict_unit #(.NUM_CORES(NC), .NUM_LINES(NL), .TS_W(TW)) u_dut (
    .clk(clk), .rstN(rstN), .beginTx(beginTx), .commitTx(commitTx),
    .reqValid(reqValid), .reqCore(reqCore), .reqTrans(reqTrans),
    .reqWrite(reqWrite), .reqLine(reqLine), .reqNack(reqNack),
    .reqAbort(reqAbort), .txActive(txActive), .stalled(stalled), .txStamp(txStamp)
  );

  // Reference state kept from the requirements.
  bit [NC-1:0] mRd [NL];
  bit [NC-1:0] mWr [NL];
  bit [NC-1:0] mAct, mTsV, mCyc;
  int          mTs [NC];
  bit [NC-1:0] mWait [NC];
  int          mCnt;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic void modelReset();
    for (int l = 0; l < NL; l++) begin mRd[l] = '0; mWr[l] = '0; end
    mAct = '0; mTsV = '0; mCyc = '0; mCnt = 0;
    for (int c = 0; c < NC; c++) begin mTs[c] = 0; mWait[c] = '0; end
  endfunction

  function automatic bit older(input int a, input int b);
    return (mTs[a] < mTs[b]) || (mTs[a] == mTs[b] && a < b);
  endfunction

  // R2 R3 R4 conflict rule
  function automatic bit [NC-1:0] conflicts(input bit v, input int r, input bit w, input int l);
    bit [NC-1:0] cv = '0;
    if (v)
      for (int j = 0; j < NC; j++)
        if (j != r) cv[j] = w ? (mRd[l][j] | mWr[l][j]) : mWr[l][j];
    return cv;
  endfunction

  // R9 abort rule
  function automatic bit expAbortOf(input bit v, input int r, input bit tr, input bit w, input int l);
    bit [NC-1:0] cv = conflicts(v, r, w, l);
    bit olderHold = 1'b0;
    for (int j = 0; j < NC; j++) if (cv[j] && older(j, r)) olderHold = 1'b1;
    return (cv != 0) && tr && mAct[r] && mCyc[r] && olderHold;
  endfunction

  function automatic void modelStep(input bit [NC-1:0] b, input bit [NC-1:0] cm, input bit v,
                                    input int r, input bit tr, input bit w, input int l);
    bit [NC-1:0] cv = conflicts(v, r, w, l);
    bit ab = expAbortOf(v, r, tr, w, l);
    bit nk = (cv != 0) && !ab;
    bit eff = v && tr && mAct[r];
    bit [NC-1:0] abV = ab ? (NC'(1) << r) : '0;
    bit [NC-1:0] endN = (cm & mAct) | abV;
    bit [NC-1:0] bgV = b & ~mAct;
    bit [NC-1:0] fs = '0;
    bit anyNew = 1'b0;
    if (cv != 0 && eff && !ab)
      for (int j = 0; j < NC; j++) if (cv[j] && older(r, j)) fs[j] = 1'b1;
    for (int li = 0; li < NL; li++) begin
      mRd[li] &= ~endN;
      mWr[li] &= ~endN;
    end
    if (eff && cv == 0) begin
      if (w) mWr[l][r] = 1'b1; else mRd[l][r] = 1'b1;
    end
    for (int c = 0; c < NC; c++) begin
      if (v && r == c) mWait[c] = nk ? (cv & ~endN) : '0;
      else             mWait[c] = mWait[c] & ~endN;
    end
    for (int c = 0; c < NC; c++) begin
      if (abV[c]) begin mAct[c] = 0; mCyc[c] = 0; end
      else if (cm[c] && mAct[c]) begin mAct[c] = 0; mTsV[c] = 0; mCyc[c] = 0; end
      else if (bgV[c]) begin
        mAct[c] = 1; mCyc[c] = 0;
        if (!mTsV[c]) begin mTsV[c] = 1; mTs[c] = mCnt; anyNew = 1'b1; end
      end else if (fs[c]) mCyc[c] = 1;
    end
    if (anyNew) mCnt++;
  endfunction

  task automatic stateCheck();
    check("R5/R6/R10 stalled", int'(stalled), int'(mWait[0] != 0) | (int'(mWait[1] != 0) << 1) |
          (int'(mWait[2] != 0) << 2) | (int'(mWait[3] != 0) << 3));
    check("R6/R10 txActive", int'(txActive), int'(mAct));
    for (int c = 0; c < NC; c++)
      if (mTsV[c]) check("R8 stamp", int'(txStamp[c*TW +: TW]), mTs[c] & 16'hFFFF);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input bit [NC-1:0] b, input bit [NC-1:0] cm, input bit v, input int r,
                      input bit tr, input bit w, input int l, input string tag);
    beginTx = b; commitTx = cm; reqValid = v; reqCore = 2'(r);
    reqTrans = tr; reqWrite = w; reqLine = 4'(l);
    #1;
    begin
      bit ea = expAbortOf(v, r, tr, w, l);
      bit en = (conflicts(v, r, w, l) != 0) && !ea;
      check({tag, " nack"}, int'(reqNack), int'(en));
      check({tag, " R9 abort"}, int'(reqAbort), int'(ea));
    end
    @(posedge clk);
    modelStep(b, cm, v, r, tr, w, l);
    @(negedge clk);
    stateCheck();
  endtask

  task automatic idle(); step('0, '0, 0, 0, 0, 0, 0, "idle"); endtask

  task automatic doReset();
    rstN = 1'b0;
    beginTx = '0; commitTx = '0; reqValid = 0;
    repeat (3) @(negedge clk);
    modelReset();
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    @(negedge clk);
    doReset();
    // R1 reset state
    #1;
    check("R1 txActive", int'(txActive), 0);
    check("R1 stalled", int'(stalled), 0);
    check("R1 nack", int'(reqNack), 0);
    check("R1 abort", int'(reqAbort), 0);
    @(negedge clk);

    // Directed sharing and conflict patterns
    step(4'b0011, '0, 0, 0, 0, 0, 0, "R8 begin");
    check("R8 same-cycle stamp", int'(txStamp[0 +: TW]), int'(txStamp[TW +: TW]));
    step('0, '0, 1, 0, 1, 0, 1, "R2 read fresh");
    step('0, '0, 1, 1, 1, 0, 1, "R2 read-read");
    step('0, '0, 1, 1, 1, 1, 1, "R3 write over read");
    step('0, '0, 1, 0, 1, 1, 2, "R3 write fresh");
    step('0, '0, 1, 1, 1, 0, 2, "R2 read over write");
    step('0, '0, 1, 0, 1, 0, 2, "R4 own line");
    step('0, '0, 1, 0, 1, 1, 2, "R4 own write");
    step('0, '0, 1, 2, 0, 0, 2, "R7 nontrans nack");
    step('0, '0, 1, 2, 0, 1, 5, "R7 nontrans grant");
    step(4'b1000, '0, 0, 0, 0, 0, 0, "R8 begin late");
    step('0, '0, 1, 3, 1, 1, 5, "R7 no mark left");
    step('0, 4'b0001, 0, 0, 0, 0, 0, "R6 commit");
    step('0, '0, 1, 1, 1, 0, 2, "R6 retry");
    step('0, '0, 1, 2, 0, 0, 2, "R6 nontrans retry");

    // Directed deadlock crossing
    doReset();
    step(4'b0001, '0, 0, 0, 0, 0, 0, "R8 begin old");
    step(4'b0010, '0, 0, 0, 0, 0, 0, "R8 begin young");
    check("R8 counter order", int'(txStamp[TW +: TW]), 1);
    step('0, '0, 1, 0, 1, 1, 3, "R3 old write");
    step('0, '0, 1, 1, 1, 1, 4, "R3 young write");
    step('0, '0, 1, 0, 1, 1, 4, "R9 old stalls");
    step('0, '0, 1, 1, 1, 1, 3, "R9 young aborts");
    step('0, '0, 1, 0, 1, 1, 4, "R10 retry after abort");
    step(4'b0010, '0, 0, 0, 0, 0, 0, "R8 restart");
    check("R8 stamp kept", int'(txStamp[TW +: TW]), 1);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % NC);
      bit v = ($urandom % 10) < 8;
      bit tr = ($urandom % 10) < 8;
      bit w = $urandom % 2;
      int l = int'($urandom % 4);
      bit [NC-1:0] b = '0, cm = '0;
      for (int c = 0; c < NC; c++) begin
        if (!(v && c == r)) begin
          b[c]  = ($urandom % 5) == 0;
          cm[c] = ($urandom % 12) == 0;
        end
      end
      step(b, cm, v, r, tr, w, l, "R2 R3 R9 random");
    end
    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule